// File: doc/BRIEF.md
# Hit Frame Formatter

This block turns the result of one bunch crossing's hit selection into an 80-bit frame. The frame leaves as two 40-bit words on consecutive clock cycles. The input is a 32-bit flag vector that marks the selected sources, together with a 6-bit timing/address (ART) value for every source. A format input picks one of two layouts:

- **Chip-ID format** tags each hit with its 5-bit source number and carries up to seven hits. The three top bits of the frame hold the hit count.
- **Hit-list format** carries a 32-bit occupancy bitmap followed by up to eight ART fields.

In both formats, hits are taken in ascending source order. If more sources are flagged than a format can carry, the highest-numbered ones are dropped.

A frame request is taken on a clock edge together with the flags, ART values and format. On the next cycle the lower word appears, marked by a start strobe. The upper word follows one cycle later. A new request can be taken on the same edge that presents the upper word, so frames can stream back-to-back every two cycles. A request that arrives while the lower word is being presented is dropped.

Top module: `hit_frame_fmt`

## Requirements
- R1: While reset is held, and in every idle cycle afterwards, `dout_valid` and `frame_start` are 0 and `dout` is all zeros.
- R2: A request (`frame_valid`=1) accepted at an edge produces the following, then the outputs go idle unless another frame was accepted:
  - on the next cycle: `dout` = frame[39:0], `frame_start`=1, `dout_valid`=1;
  - on the cycle after that: `dout` = frame[79:40], `frame_start`=0, `dout_valid`=1.
- R3: A request that arrives in a cycle where `frame_start` is 1 is ignored. The frame in flight finishes unchanged and no extra frame follows.
- R4: A request that arrives in a cycle where the upper word is shown is accepted. Its lower word appears on the very next cycle.
- R5: `fmt_sel` is sampled only together with an accepted request (0 = chip-ID, 1 = hit-list). Changing it at any other time does not alter the frame in flight.
- R6: Chip-ID format places hit k (k = 0..6) in frame bits [11k+10:11k]. Its source number sits in [11k+4:11k] and that source's ART value in [11k+10:11k+5]. Hits fill the slots in ascending source order.
- R7: Chip-ID format writes the number of reported hits, min(flagged count, 7), into frame bits [79:77]. Flagged sources beyond the seventh are not reported.
- R8: Hit-list format sets frame bit i (i < 32) for each reported source, where the reported sources are the eight lowest-numbered flagged ones. The ART value of the k-th reported source goes to bits [32+6k+5:32+6k].
- R9: Every slot with no hit is all zeros. With no flags set, the whole frame is zero in both formats. A single hit on source 0 with ART 0 is still told apart from an empty frame: by the count field in chip-ID format, and by bitmap bit 0 in hit-list format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Frame request for this crossing |
| fmt_sel | input | 1 | Format: 0 chip-ID, 1 hit-list |
| src_flags | input | 32 | Selected sources, bit i = source i |
| src_art | input | 192 | ART value of source i in bits [6i+5:6i] |
| dout | output | 40 | Current frame word |
| dout_valid | output | 1 | `dout` carries a frame word |
| frame_start | output | 1 | `dout` is the lower word of a frame |

## Verification
Two functions share a cycle in this block:
- the acceptance of a new request and the output of the previous frame's upper word;
- the arrival of a request and the output of the lower word, in which case the request must be dropped.

The bench drives requests on consecutive cycles and in long random patterns, while toggling the format and the flags in mid-frame. A behavioural model predicts every word, start strobe and valid flag. These predictions are compared with the outputs on every clock. A wrong acceptance rule shows up as a shifted, missing or extra frame word.

// File: rtl/hff_pkg.sv
package hff_pkg;
  localparam int unsigned NSRC      = 32;
  localparam int unsigned ARTW      = 6;
  localparam int unsigned IDW       = $clog2(NSRC);
  localparam int unsigned FRAMEW    = 80;
  localparam int unsigned HALFW     = FRAMEW / 2;
  localparam int unsigned CID_SLOTS = 7;
  localparam int unsigned HL_SLOTS  = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } phase_t;

  typedef enum logic {
    FMT_CHIPID  = 1'b0,
    FMT_HITLIST = 1'b1
  } fmt_t;
endpackage

// File: rtl/hff_pick.sv
// Ascending-order slot assignment: the first SLOTS flagged sources get slots.
module hff_pick #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IDW   = 5,
  localparam int unsigned CW   = $clog2(SLOTS + 1)
) (
  input  logic [NSRC-1:0]       flags,
  output logic [SLOTS-1:0]      slot_vld,
  output logic [SLOTS*IDW-1:0]  slot_id,
  output logic [NSRC-1:0]       kept,
  output logic [CW-1:0]         n_kept
);
  always_comb begin
    logic [CW-1:0] rank;
    rank     = '0;
    slot_vld = '0;
    slot_id  = '0;
    kept     = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (flags[i] && (rank < CW'(SLOTS))) begin
        for (int k = 0; k < SLOTS; k++) begin
          if (rank == CW'(k)) begin
            slot_vld[k]             = 1'b1;
            slot_id[k*IDW +: IDW]   = IDW'(i);
          end
        end
        kept[i] = 1'b1;
        rank    = rank + CW'(1);
      end
    end
    n_kept = rank;
  end
endmodule

// File: rtl/hff_pack.sv
// Builds the 80-bit frame for either format from the two slot assignments.
module hff_pack
  import hff_pkg::*;
#(
  parameter int unsigned NSR   = NSRC,
  parameter int unsigned AW    = ARTW,
  parameter int unsigned IW    = IDW,
  parameter int unsigned FW    = FRAMEW,
  parameter int unsigned CSL   = CID_SLOTS,
  parameter int unsigned HSL   = HL_SLOTS,
  localparam int unsigned CNW  = $clog2(CSL + 1),
  localparam int unsigned CSW  = IW + AW
) (
  input  logic                 fmt,
  input  logic [NSR*AW-1:0]    art_tbl,
  input  logic [CSL-1:0]       cid_vld,
  input  logic [CSL*IW-1:0]    cid_ids,
  input  logic [CNW-1:0]       cid_n,
  input  logic [HSL-1:0]       hl_vld,
  input  logic [HSL*IW-1:0]    hl_ids,
  input  logic [NSR-1:0]       hl_kept,
  output logic [FW-1:0]        frame
);
  function automatic logic [AW-1:0] art_of(input logic [IW-1:0] id,
                                           input logic [NSR*AW-1:0] tbl);
    logic [AW-1:0] r;
    r = '0;
    for (int s = 0; s < NSR; s++) begin
      if (id == IW'(s)) r = tbl[s*AW +: AW];
    end
    return r;
  endfunction

  logic [AW-1:0] cid_art [CSL];
  logic [AW-1:0] hl_art  [HSL];

  for (genvar k = 0; k < CSL; k++) begin : g_cid_art
    always_comb cid_art[k] = art_of(cid_ids[k*IW +: IW], art_tbl);
  end

  for (genvar k = 0; k < HSL; k++) begin : g_hl_art
    always_comb hl_art[k] = art_of(hl_ids[k*IW +: IW], art_tbl);
  end

  always_comb begin
    frame = '0;
    if (fmt_t'(fmt) == FMT_CHIPID) begin
      for (int k = 0; k < CSL; k++) begin
        if (cid_vld[k]) frame[k*CSW +: CSW] = {cid_art[k], cid_ids[k*IW +: IW]};
      end
      frame[FW-1 -: CNW] = cid_n;
    end else begin
      frame[NSR-1:0] = hl_kept;
      for (int k = 0; k < HSL; k++) begin
        if (hl_vld[k]) frame[NSR + k*AW +: AW] = hl_art[k];
      end
    end
  end
endmodule

// File: rtl/hff_seq.sv
// Holds the accepted frame and presents it as lower word then upper word.
module hff_seq
  import hff_pkg::*;
#(
  parameter int unsigned FW   = FRAMEW,
  localparam int unsigned HW  = FW / 2
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          req,
  input  logic [FW-1:0] frame_in,
  output logic [HW-1:0] dout,
  output logic          dout_valid,
  output logic          frame_start
);
  phase_t        phase_q, phase_d;
  logic [FW-1:0] frame_q;
  logic          accept;

  assign accept = req && (phase_q != PH_LO);

  always_comb begin
    phase_d = PH_IDLE;
    if (accept)                phase_d = PH_LO;
    else if (phase_q == PH_LO) phase_d = PH_HI;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     frame_q <= '0;
    else if (accept) frame_q <= frame_in;
  end

  always_comb begin
    dout        = '0;
    dout_valid  = 1'b0;
    frame_start = 1'b0;
    case (phase_q)
      PH_LO: begin
        dout = frame_q[HW-1:0]; dout_valid = 1'b1; frame_start = 1'b1;
      end
      PH_HI: begin
        dout = frame_q[FW-1:HW]; dout_valid = 1'b1;
      end
      default: ;
    endcase
  end

  assert_start_valid_R2: assert property (@(posedge clk) disable iff (!srst_n)
    frame_start |-> dout_valid);
  assert_upper_follows_R2: assert property (@(posedge clk) disable iff (!srst_n)
    frame_start |=> (dout_valid && !frame_start));
  assert_hold_in_flight_R3: assert property (@(posedge clk) disable iff (!srst_n)
    frame_start |=> $stable(frame_q));
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!srst_n)
    !dout_valid |-> (dout == '0));
endmodule

// File: rtl/hit_frame_fmt.sv
module hit_frame_fmt
  import hff_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_valid,
  input  logic                  fmt_sel,
  input  logic [NSRC-1:0]       src_flags,
  input  logic [NSRC*ARTW-1:0]  src_art,
  output logic [HALFW-1:0]      dout,
  output logic                  dout_valid,
  output logic                  frame_start
);
  localparam int unsigned CNW = $clog2(CID_SLOTS + 1);
  localparam int unsigned HNW = $clog2(HL_SLOTS + 1);

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic [CID_SLOTS-1:0]     cid_vld;
  logic [CID_SLOTS*IDW-1:0] cid_ids;
  logic [NSRC-1:0]          cid_kept;
  logic [CNW-1:0]           cid_n;
  logic [HL_SLOTS-1:0]      hl_vld;
  logic [HL_SLOTS*IDW-1:0]  hl_ids;
  logic [NSRC-1:0]          hl_kept;
  logic [HNW-1:0]           hl_n;
  logic [FRAMEW-1:0]        frame;

  hff_pick #(.NSRC(NSRC), .SLOTS(CID_SLOTS), .IDW(IDW)) u_pick_cid (
    .flags(src_flags), .slot_vld(cid_vld), .slot_id(cid_ids),
    .kept(cid_kept), .n_kept(cid_n));

  hff_pick #(.NSRC(NSRC), .SLOTS(HL_SLOTS), .IDW(IDW)) u_pick_hl (
    .flags(src_flags), .slot_vld(hl_vld), .slot_id(hl_ids),
    .kept(hl_kept), .n_kept(hl_n));

  hff_pack u_pack (
    .fmt(fmt_sel), .art_tbl(src_art),
    .cid_vld(cid_vld), .cid_ids(cid_ids), .cid_n(cid_n),
    .hl_vld(hl_vld), .hl_ids(hl_ids), .hl_kept(hl_kept),
    .frame(frame));

  hff_seq u_seq (
    .clk(clk), .srst_n(srst_n), .req(frame_valid), .frame_in(frame),
    .dout(dout), .dout_valid(dout_valid), .frame_start(frame_start));

  assert_bitmap_count_R8: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(hl_kept) == int'(hl_n));
  assert_cid_subset_R7: assert property (@(posedge clk) disable iff (!srst_n)
    ((cid_kept & ~hl_kept) == '0) && ($countones(cid_kept) == int'(cid_n)));
endmodule

// File: tb/hit_frame_fmt_tb_top.sv
module hit_frame_fmt_tb_top;
  logic         clk;
  logic         rst_n;
  logic         frame_valid;
  logic         fmt_sel;
  logic [31:0]  src_flags;
  logic [191:0] src_art;
  logic [39:0]  dout;
  logic         dout_valid;
  logic         frame_start;

  int n_cmp  = 0;
  int n_fail = 0;
  int cycles = 0;
  string cur_req = "R1";

  int          m_phase = 0;
  logic [79:0] m_frame = '0;

  hit_frame_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .fmt_sel(fmt_sel),
    .src_flags(src_flags), .src_art(src_art),
    .dout(dout), .dout_valid(dout_valid), .frame_start(frame_start));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected frame, written from the format requirements R6..R9.
  function automatic logic [79:0] build(input logic m, input logic [31:0] f,
                                        input logic [191:0] a);
    logic [79:0] r;
    int n;
    r = '0;
    n = 0;
    for (int s = 0; s < 32; s++) begin
      if (f[s]) begin
        if (!m && n < 7) begin
          r[n*11 +: 5]    = 5'(s);
          r[n*11+5 +: 6]  = a[s*6 +: 6];
          n++;
        end else if (m && n < 8) begin
          r[s]            = 1'b1;
          r[32+n*6 +: 6]  = a[s*6 +: 6];
          n++;
        end
      end
    end
    if (!m) r[79:77] = 3'(n);
    return r;
  endfunction

  task automatic compare();
    logic [39:0] e_d;
    logic e_v, e_s;
    e_d = '0; e_v = 1'b0; e_s = 1'b0;
    if (m_phase == 1) begin e_d = m_frame[39:0];  e_v = 1'b1; e_s = 1'b1; end
    if (m_phase == 2) begin e_d = m_frame[79:40]; e_v = 1'b1; end
    n_cmp++;
    if (dout !== e_d || dout_valid !== e_v || frame_start !== e_s) begin
      n_fail++;
      $display("FAIL %s: dout=%h valid=%b start=%b expected dout=%h valid=%b start=%b",
               cur_req, dout, dout_valid, frame_start, e_d, e_v, e_s);
    end
  endtask

  // One cycle: check outputs, drive inputs, advance model over the next edge.
  task automatic step(input logic fv, input logic m, input logic [31:0] f,
                      input logic [191:0] a);
    compare();
    frame_valid = fv; fmt_sel = m; src_flags = f; src_art = a;
    if (rst_n && fv && m_phase != 1) begin
      m_frame = build(m, f, a);
      m_phase = 1;
    end else if (m_phase == 1) m_phase = 2;
    else m_phase = 0;
    @(negedge clk);
  endtask

  function automatic logic [191:0] rand_art();
    logic [191:0] r;
    for (int i = 0; i < 6; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, $urandom_range(0, 1), $urandom, rand_art());
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    logic [191:0] a;
    frame_valid = 1'b0; fmt_sel = 1'b0; src_flags = '0; src_art = '0;
    rst_n = 1'b0;
    @(negedge clk);
    // R1: reset state, with a request pending during reset
    cur_req = "R1";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 32'hFFFF_FFFF, rand_art());
    rst_n = 1'b1;
    step(1'b0, 1'b0, '0, '0);
    step(1'b0, 1'b0, '0, '0);
    idle(3);

    // R6, R7: chip-ID format, few hits
    cur_req = "R6";
    step(1'b1, 1'b0, 32'h8001_0204, rand_art());
    idle(3);
    // R7: more than seven flags, truncation and count
    cur_req = "R7";
    step(1'b1, 1'b0, 32'h0F0F_F00F, rand_art());
    idle(3);
    // R9: empty frame and the source-0/ART-0 case in both formats
    cur_req = "R9";
    step(1'b1, 1'b0, 32'h0, rand_art());
    idle(3);
    a = rand_art(); a[5:0] = 6'd0;
    step(1'b1, 1'b0, 32'h1, a);
    idle(3);
    step(1'b1, 1'b1, 32'h1, a);
    idle(3);
    step(1'b1, 1'b1, 32'h0, a);
    idle(3);
    // R8: hit-list format, under and over eight flags
    cur_req = "R8";
    step(1'b1, 1'b1, 32'h0000_4812, rand_art());
    idle(3);
    step(1'b1, 1'b1, 32'hF0F0_F0F1, rand_art());
    idle(3);
    step(1'b1, 1'b1, 32'hFFFF_FFFF, rand_art());
    idle(3);
    // R4: back-to-back frames every two cycles, alternating formats
    cur_req = "R4";
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'(i), $urandom, rand_art());
      step(1'b0, 1'(~i), $urandom, rand_art());
    end
    idle(3);
    // R3: requests held high on every cycle, half must be dropped
    cur_req = "R3";
    for (int i = 0; i < 10; i++) step(1'b1, 1'($urandom), $urandom, rand_art());
    idle(3);
    // R5: format and flags toggled while a frame is in flight
    cur_req = "R5";
    step(1'b1, 1'b0, 32'h0000_00FF, rand_art());
    step(1'b0, 1'b1, 32'hFFFF_0000, rand_art());
    step(1'b0, 1'b0, 32'h1234_5678, rand_art());
    idle(3);
    // R2: random traffic
    cur_req = "R2";
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 2) != 0), 1'($urandom), $urandom & $urandom, rand_art());
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule